// File: doc/BRIEF.md
# Daisy-Chain Address Enumeration Sequencer

This block sits on the host side of a serial command path shared by a chain of identical devices. Every device comes out of reset answering to address 0, so a plain command reaches all of them at once. To give each device its own address, the sequencer first sends one broadcast frame. That frame tells every device to stop passing frames further down the chain. It then sends one set-address frame per device. Only the nearest device that still answers to address 0 takes each frame, stores the new address, and starts passing frames on again. The next set-address frame therefore reaches the next device along the chain.

Frames come out one byte at a time on a valid/ready byte port, which an external UART transmitter serializes. Each run is started by a one-cycle pulse. The address step and the device count are taken at that pulse. Addresses begin at 0 and grow by the step, so the devices split a 32-bit nonce space evenly. A fixed idle gap follows every frame, giving the devices time to change their relay state. The block stops once the requested number of devices has been addressed.

Top module: `enum_chain_seq`

## Requirements
- R1: After reset, tx_valid_o, busy_o and done_o are low and addressed_o is 0.
- R2: A start pulse while idle first emits the chain-halt frame of three bytes 0x55, 0xAA, 0x60, where the third byte holds type 3 in bits [7:5] and command code 0 in bits [4:0].
- R3: After the chain-halt frame, exactly count_i set-address frames follow. Each is four bytes: 0x55, 0xAA, 0x41 (type 2 in bits [7:5], command code 1 in bits [4:0]), then the address byte.
- R4: The first set-address frame carries address 0, and each later frame carries the previous address plus step_i, modulo 256.
- R5: step_i and count_i are sampled only on the accepted start pulse, and changing them during a run has no effect on the frames.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged. A frame is never cut short or interleaved with another.
- R7: After the last byte of each frame is accepted, tx_valid_o stays low for exactly GAP_CYCLES clock cycles before the next frame starts, or before done_o rises.
- R8: busy_o is high from the cycle after an accepted start until the last gap ends. done_o then rises and stays high until the next accepted start, and addressed_o equals the sampled count.
- R9: A start pulse while busy_o is high is ignored.
- R10: With count_i equal to 0, only the chain-halt frame is sent before done_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins an enumeration run |
| step_i | input | ADDR_W | Address increment between devices |
| count_i | input | CNT_W | Number of devices to address |
| tx_valid_o | output | 1 | Byte on tx_data_o is valid |
| tx_data_o | output | 8 | Frame byte to the UART transmitter |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |
| busy_o | output | 1 | Enumeration run in progress |
| done_o | output | 1 | Last run finished; held until next start |
| addressed_o | output | CNT_W | Number of set-address frames sent in this run |

## Verification
A wrong address register shows up in the fourth byte of the very next set-address frame. A wrong device counter shows up as one frame too many or too few before done_o rises, and as a mismatch on addressed_o. A corrupted byte index or frame kind breaks the preamble or header byte of the frame in flight, within a few cycles. A gap counter error changes the measured run of low tx_valid_o cycles at the end of the first frame.

// File: rtl/enum_seq_pkg.sv
// Shared constants and types for the enumeration sequencer.
// Assumes an 8-bit byte stream toward the UART transmitter.
package enum_seq_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam logic [7:0]  SYNC_A = 8'h55;
    localparam logic [7:0]  SYNC_B = 8'hAA;
    localparam logic [2:0]  TYPE_CHAIN_HALT = 3'd3;
    localparam logic [2:0]  TYPE_CHIP_CMD   = 3'd2;
    localparam logic [4:0]  CMD_HALT        = 5'd0;
    localparam logic [4:0]  CMD_SET_ADDR    = 5'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    typedef enum logic {
        FR_HALT = 1'b0,
        FR_ADDR = 1'b1
    } frame_kind_t;
endpackage

// File: rtl/enum_frame_fmt.sv
// Frame formatter: picks the byte at a given index of a chain-halt or
// set-address frame and flags the final byte. Purely combinational.
// Assumes ADDR_W <= 8 so the address fits one byte.
module enum_frame_fmt
    import enum_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 2
) (
    input  frame_kind_t        kind_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [BYTE_W-1:0]  byte_o,
    output logic               last_o
);
    localparam logic [IDX_W-1:0] HALT_LAST = IDX_W'(2);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(3);

    logic [BYTE_W-1:0] header;
    logic [BYTE_W-1:0] addr_byte;

    // Header byte: frame type in the top bits, command code below.
    always_comb begin
        if (kind_i == FR_HALT) header = {TYPE_CHAIN_HALT, CMD_HALT};
        else                   header = {TYPE_CHIP_CMD, CMD_SET_ADDR};
    end

    // Zero-extend the device address into one byte.
    always_comb begin
        addr_byte = '0;
        addr_byte[ADDR_W-1:0] = addr_i;
    end

    // Byte select by position within the frame.
    always_comb begin
        case (idx_i)
            IDX_W'(0): byte_o = SYNC_A;
            IDX_W'(1): byte_o = SYNC_B;
            IDX_W'(2): byte_o = header;
            default:   byte_o = addr_byte;
        endcase
    end

    // Final-byte flag depends on frame length.
    always_comb begin
        last_o = (kind_i == FR_HALT) ? (idx_i == HALT_LAST) : (idx_i == ADDR_LAST);
    end
endmodule

// File: rtl/enum_gap_timer.sv
// Inter-frame gap timer: after load_i, expired_o stays low for
// GAP_CYCLES-1 cycles and is then high. With the sequencer this gives
// exactly GAP_CYCLES idle cycles. Assumes GAP_CYCLES >= 1.
module enum_gap_timer #(
    parameter int unsigned GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on frame end, count down to zero, hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R7: a load always restarts a full gap when the gap is longer than one cycle.
    p_gap_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (expired_o == (GAP_CYCLES == 1)));
endmodule

// File: rtl/enum_addr_track.sv
// Address and device tracker: holds the sampled step and target count,
// the next address to assign and the number of devices addressed.
// Assumes init_i and advance_i are never high in the same cycle.
module enum_addr_track #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              advance_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  sent_o,
    output logic              all_sent_o
);
    logic [ADDR_W-1:0] step_q;
    logic [CNT_W-1:0]  target_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  sent_q;

    // Capture run parameters only when a run starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            target_q <= '0;
        end else if (init_i) begin
            step_q   <= step_i;
            target_q <= count_i;
        end
    end

    // Next address and device counter, cleared at run start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            sent_q <= '0;
        end else if (init_i) begin
            addr_q <= '0;
            sent_q <= '0;
        end else if (advance_i) begin
            addr_q <= addr_q + step_q;
            sent_q <= sent_q + 1'b1;
        end
    end

    assign addr_o     = addr_q;
    assign sent_o     = sent_q;
    assign all_sent_o = (sent_q == target_q);

    // R3: never more set-address frames than the sampled count.
    p_no_overcount_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q <= target_q);

    // R4: each accepted advance moves the address by the sampled step.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !init_i) |=> (addr_q == $past(addr_q) + $past(step_q)));
endmodule

// File: rtl/enum_chain_seq.sv
// Top of the enumeration sequencer. Sends one chain-halt frame and then
// one set-address frame per device on a valid/ready byte port, with a
// fixed idle gap after every frame. Assumes the downstream transmitter
// follows the usual valid/ready rule: a byte moves when both are high.
module enum_chain_seq
    import enum_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned GAP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] step_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              tx_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  addressed_o
);
    localparam int unsigned IDX_W = 2;

    seq_state_t        state_q;
    frame_kind_t       kind_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;

    logic              byte_last;
    logic              byte_take;
    logic              frame_end;
    logic              run_init;
    logic              gap_over;
    logic              all_sent;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  sent_cnt;
    logic [7:0]        cur_byte;

    // Handshake and event decode.
    always_comb begin
        byte_take = (state_q == ST_SEND) && tx_ready_i;
        frame_end = byte_take && byte_last;
        run_init  = (state_q == ST_IDLE) && start_i;
    end

    enum_frame_fmt #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) fmt_i (
        .kind_i (kind_q),
        .idx_i  (idx_q),
        .addr_i (cur_addr),
        .byte_o (cur_byte),
        .last_o (byte_last)
    );

    enum_gap_timer #(
        .GAP_CYCLES (GAP_CYCLES)
    ) gap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (frame_end),
        .expired_o (gap_over)
    );

    enum_addr_track #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) trk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (run_init),
        .advance_i  (frame_end && (kind_q == FR_ADDR)),
        .step_i     (step_i),
        .count_i    (count_i),
        .addr_o     (cur_addr),
        .sent_o     (sent_cnt),
        .all_sent_o (all_sent)
    );

    // Sequencer: idle, stream a frame byte by byte, then wait out the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= FR_HALT;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SEND;
                        kind_q  <= FR_HALT;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (byte_take) begin
                        if (byte_last) begin
                            idx_q   <= '0;
                            state_q <= ST_GAP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_over) begin
                        if (all_sent) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            kind_q  <= FR_ADDR;
                            state_q <= ST_SEND;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_valid_o  = (state_q == ST_SEND);
    assign tx_data_o   = cur_byte;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign addressed_o = sent_cnt;

    // R6: a stalled byte is held unchanged until taken.
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R2: every frame opens with the first sync byte.
    p_sync_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> (tx_data_o == SYNC_A));

    // R8: a finished run is quiet and not busy.
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!tx_valid_o && !busy_o));

    // R9: a start while busy leaves the device counter untouched.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tx_valid_o) |=> $stable(addressed_o));
endmodule

// File: tb/enum_chain_seq_tb_top.sv
// Scoreboard bench: the driver pushes expected bytes, the monitor pops
// and compares each accepted byte and measures gaps and stalls.
module enum_chain_seq_tb_top;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] step_i = '0;
    logic [7:0] count_i = '0;
    logic       tx_valid_o;
    logic [7:0] tx_data_o;
    logic       tx_ready_i = 1'b1;
    logic       busy_o;
    logic       done_o;
    logic [7:0] addressed_o;

    int errors = 0;
    int checks = 0;
    bit throttle = 1'b0;
    bit ended = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    int  low_run = 0;
    bit  stalled = 1'b0;
    logic [7:0] stall_byte = '0;

    always #5 clk = ~clk;

    enum_chain_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .step_i      (step_i),
        .count_i     (count_i),
        .tx_valid_o  (tx_valid_o),
        .tx_data_o   (tx_data_o),
        .tx_ready_i  (tx_ready_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .addressed_o (addressed_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready_i = throttle ? lfsr[0] : 1'b1;
    end

    // Monitor: sample at the falling edge, compare bytes, gaps and stalls.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled) begin
                check(tx_valid_o === 1'b1 && tx_data_o === stall_byte,
                      "R6 stalled byte held", int'(tx_data_o), int'(stall_byte));
            end
            stalled = 1'b0;
            if (tx_valid_o) begin
                if (low_run > 0)
                    check(low_run == GAP, "R7 gap between frames", low_run, GAP);
                low_run = 0;
                if (tx_ready_i) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected extra byte", int'(tx_data_o), -1);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(tx_data_o === e, t, int'(tx_data_o), int'(e));
                    end
                end else begin
                    stalled = 1'b1;
                    stall_byte = tx_data_o;
                end
            end else if (busy_o) begin
                low_run++;
            end
        end
    end

    // Driver: queue expected frames, pulse start, wait for done, check end state.
    task automatic run_enum(input logic [7:0] stp, input logic [7:0] cnt,
                            input bit thr, input bit disturb);
        logic [7:0] a;
        int wait_cyc;
        throttle = thr;
        exp_q.push_back(8'h55); tag_q.push_back("R2 halt sync0");
        exp_q.push_back(8'hAA); tag_q.push_back("R2 halt sync1");
        exp_q.push_back(8'h60); tag_q.push_back("R2 halt header");
        a = 8'h00;
        for (int i = 0; i < int'(cnt); i++) begin
            exp_q.push_back(8'h55); tag_q.push_back("R3 addr sync0");
            exp_q.push_back(8'hAA); tag_q.push_back("R3 addr sync1");
            exp_q.push_back(8'h41); tag_q.push_back("R3 addr header");
            exp_q.push_back(a);     tag_q.push_back("R4 address byte");
            a = a + stp;
        end
        @(posedge clk); #1;
        step_i = stp; count_i = cnt; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        check(busy_o === 1'b1, "R8 busy after start", int'(busy_o), 1);
        check(done_o === 1'b0, "R8 done cleared by start", int'(done_o), 0);
        if (disturb) begin
            repeat (9) @(posedge clk);
            #1;
            step_i = 8'd99; count_i = 8'd1; start_i = 1'b1;   // R5 and R9 stimulus
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        wait_cyc = 0;
        while (done_o !== 1'b1 && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(low_run == GAP, "R7 final gap before done", low_run, GAP);
        low_run = 0;
        check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
        check(addressed_o === cnt, "R8 addressed count", int'(addressed_o), int'(cnt));
        check(busy_o === 1'b0, "R8 not busy at done", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        check(done_o === 1'b1 && tx_valid_o === 1'b0, "R8 done held, port quiet",
              int'(done_o), 1);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_valid_o === 1'b0, "R1 valid low", int'(tx_valid_o), 0);
        check(busy_o === 1'b0, "R1 busy low", int'(busy_o), 0);
        check(done_o === 1'b0, "R1 done low", int'(done_o), 0);
        check(addressed_o === 8'd0, "R1 count zero", int'(addressed_o), 0);

        run_enum(8'd4, 8'd5, 1'b0, 1'b0);    // R3 R4 basic, step 4
        run_enum(8'd8, 8'd3, 1'b1, 1'b0);    // R6 throttled, step 8
        run_enum(8'd1, 8'd0, 1'b0, 1'b0);    // R10 halt frame only
        run_enum(8'd64, 8'd6, 1'b1, 1'b0);   // R4 wrap modulo 256
        run_enum(8'd4, 8'd4, 1'b0, 1'b1);    // R5 R9 mid-run disturbance
        run_enum(8'd3, 8'd2, 1'b1, 1'b1);    // R5 R9 with stalls
        summary();
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end
endmodule